// File: doc/BRIEF.md
# Transmit Line-Ending Translator with Special-Character Insertion

This block sits on the path from a transmit byte queue to an asynchronous serial transmitter. Each byte taken from the queue is either forwarded as it is or rewritten according to a two-bit translation mode. Carriage return (CR, 0x0D) may become newline (NL, 0x0A), and NL may grow into the pair CR then NL. Both sides use a valid/ready handshake, and the output path is combinational from the queue head, so a plain character costs no extra cycle.

The block can also insert one software-chosen special character into the outgoing stream. A one-cycle request captures that character. It is sent ahead of every byte still waiting in the queue, but never between the two halves of an expanded NL. Once the transmitter has accepted the special character, the block raises a one-cycle completion pulse.

Mode bit 0 selects CR-to-NL replacement and mode bit 1 selects NL expansion. The mode is expected to stay still while traffic is in flight.

Top module: `nl_xlate_tx`

## Requirements
- R1: With mode = 2'b00 every queue byte, CR and NL included, leaves unchanged and in order.
- R2: With mode bit 0 set (mode 2'b01), each CR (0x0D) is sent as one NL (0x0A) and all other bytes pass unchanged.
- R3: With mode bit 1 set (mode 2'b10), each NL (0x0A) is sent as CR (0x0D) followed by NL (0x0A) and all other bytes pass unchanged.
- R4: With mode = 2'b11, each CR becomes exactly one NL, with no further expansion, and each NL becomes CR then NL.
- R5: A captured special character is offered before any queue byte that has not yet been accepted, and the queue is not popped while it is offered.
- R6: During an NL expansion, CR and NL leave back to back and the queue byte is popped only in the cycle its NL half is accepted, so each queue byte is popped exactly once.
- R7: A special request that arrives while an expansion is half done is held until the NL half has been accepted, and is then sent before the next queue byte.
- R8: inj_done is high for exactly one cycle, the cycle after the special character was accepted on the output.
- R9: The special character is sent exactly as given, even when it is CR or NL and translation is enabled.
- R10: When out_ready is low, out_data and out_valid hold, and no character is lost or duplicated under any backpressure pattern.
- R11: A request pulse that arrives while an earlier special character is still waiting is ignored.
- R12: After reset out_valid and inj_done are low while the queue is empty and no request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 2 | Bit 0: CR to NL; bit 1: NL to CR NL |
| in_data | input | DATA_W | Byte at the head of the transmit queue |
| in_valid | input | 1 | Queue head holds a byte |
| in_ready | output | 1 | Pop the queue head this cycle |
| out_data | output | DATA_W | Byte offered to the transmitter |
| out_valid | output | 1 | out_data is valid |
| out_ready | input | 1 | Transmitter accepts out_data this cycle |
| inj_req | input | 1 | One-cycle request to insert a special character |
| inj_char | input | DATA_W | Special character, sampled with inj_req |
| inj_done | output | 1 | One-cycle pulse after the special character was accepted |

## Verification
A stuck expansion flag shows as an NL repeated or missing in the very next accepted character. A wrongly timed pop shows as a queue byte skipped or sent twice, which is caught when the collected stream is compared with the arithmetic model. A pending flag that fails to clear or to set shows within one output handshake as a repeated or absent special character, and as an inj_done pulse that lands in the wrong cycle or never appears. All 256 byte values are swept in every mode, under both steady and pseudo-random backpressure, so a corrupted translation table entry appears in the first pass through the affected code.

// File: rtl/nlx_pkg.sv
package nlx_pkg;

    localparam int MODE_W       = 2;
    localparam int MODE_CR2NL   = 0;
    localparam int MODE_NLSPLIT = 1;

    typedef struct packed {
        logic tail;
    } split_st_t;

    typedef struct packed {
        logic pend;
        logic done;
    } spec_flags_t;

endpackage

// File: rtl/nlx_classify.sv
module nlx_classify #(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] CR_CODE = 8'h0D,
    parameter logic [DATA_W-1:0] NL_CODE = 8'h0A
) (
    input  logic [DATA_W-1:0] chr,
    output logic              is_cr,
    output logic              is_nl
);
    always_comb begin
        is_cr = (chr == CR_CODE);
        is_nl = (chr == NL_CODE);
    end
endmodule

// File: rtl/nlx_map.sv
module nlx_map
    import nlx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] CR_CODE = 8'h0D,
    parameter logic [DATA_W-1:0] NL_CODE = 8'h0A
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [DATA_W-1:0] chr,
    input  logic              is_cr,
    input  logic              is_nl,
    output logic [DATA_W-1:0] first,
    output logic              split
);
    always_comb begin
        first = chr;
        split = 1'b0;
        if (is_cr && mode[MODE_CR2NL]) begin
            first = NL_CODE;
        end else if (is_nl && mode[MODE_NLSPLIT]) begin
            first = CR_CODE;
            split = 1'b1;
        end
    end
endmodule

// File: rtl/nlx_special.sv
module nlx_special
    import nlx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [DATA_W-1:0] chr_in,
    input  logic              take,
    output logic              pend,
    output logic [DATA_W-1:0] chr_out,
    output logic              done
);
    spec_flags_t       fl_d, fl_q;
    logic [DATA_W-1:0] chr_d, chr_q;

    always_comb begin
        fl_d      = fl_q;
        chr_d     = chr_q;
        fl_d.done = take;
        if (take) begin
            fl_d.pend = 1'b0;
        end else if (req && !fl_q.pend) begin
            fl_d.pend = 1'b1;
            chr_d     = chr_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q  <= '0;
            chr_q <= '0;
        end else begin
            fl_q  <= fl_d;
            chr_q <= chr_d;
        end
    end

    assign pend    = fl_q.pend;
    assign done    = fl_q.done;
    assign chr_out = chr_q;
endmodule

// File: rtl/nl_xlate_tx.sv
module nl_xlate_tx
    import nlx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] CR_CODE = 8'h0D,
    parameter logic [DATA_W-1:0] NL_CODE = 8'h0A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    input  logic              out_ready,
    input  logic              inj_req,
    input  logic [DATA_W-1:0] inj_char,
    output logic              inj_done
);
    split_st_t         st_d, st_q;
    logic              head_cr, head_nl, head_split;
    logic [DATA_W-1:0] head_first;
    logic              spec_pend, spec_take;
    logic [DATA_W-1:0] spec_chr;

    nlx_classify #(.DATA_W(DATA_W), .CR_CODE(CR_CODE), .NL_CODE(NL_CODE)) i_classify (
        .chr   (in_data),
        .is_cr (head_cr),
        .is_nl (head_nl)
    );

    nlx_map #(.DATA_W(DATA_W), .CR_CODE(CR_CODE), .NL_CODE(NL_CODE)) i_map (
        .mode  (mode),
        .chr   (in_data),
        .is_cr (head_cr),
        .is_nl (head_nl),
        .first (head_first),
        .split (head_split)
    );

    nlx_special #(.DATA_W(DATA_W)) i_special (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (inj_req),
        .chr_in  (inj_char),
        .take    (spec_take),
        .pend    (spec_pend),
        .chr_out (spec_chr),
        .done    (inj_done)
    );

    always_comb begin
        st_d      = st_q;
        out_valid = 1'b0;
        out_data  = head_first;
        in_ready  = 1'b0;
        spec_take = 1'b0;
        if (st_q.tail) begin
            // second half of an expansion: nothing may cut in
            out_valid = in_valid;
            out_data  = NL_CODE;
            in_ready  = out_ready;
            if (in_valid && out_ready) begin
                st_d.tail = 1'b0;
            end
        end else if (spec_pend) begin
            out_valid = 1'b1;
            out_data  = spec_chr;
            spec_take = out_ready;
        end else begin
            out_valid = in_valid;
            if (head_split) begin
                if (in_valid && out_ready) begin
                    st_d.tail = 1'b1;
                end
            end else begin
                in_ready = out_ready;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/nlx_check.sv
module nlx_check #(
    parameter int DATA_W = 8,
    parameter logic [DATA_W-1:0] CR_CODE = 8'h0D,
    parameter logic [DATA_W-1:0] NL_CODE = 8'h0A
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic [DATA_W-1:0] in_data,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic              inj_req,
    input logic              inj_done,
    input logic              tail,
    input logic              pend
);
    AST_SPLIT_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tail && !pend && in_valid && mode[1] && in_data == NL_CODE)
        |-> (out_data == CR_CODE && !in_ready)); // R6

    AST_SPLIT_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
        (!tail && !pend && in_valid && out_ready && mode[1] && in_data == NL_CODE)
        |=> (tail && out_data == NL_CODE)); // R3

    AST_CR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[0] && !tail && !pend && in_valid && in_data == CR_CODE)
        |-> (out_data == NL_CODE && in_ready == out_ready)); // R2

    AST_SPECIAL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !tail) |-> (out_valid && !in_ready)); // R5

    AST_DONE_AFTER: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !tail && out_ready) |=> inj_done); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        inj_done |=> !inj_done); // R8

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !inj_req) |=> (out_valid && $stable(out_data))); // R10
endmodule

bind nl_xlate_tx nlx_check #(.DATA_W(DATA_W), .CR_CODE(CR_CODE), .NL_CODE(NL_CODE)) i_nlx_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .inj_req   (inj_req),
    .inj_done  (inj_done),
    .tail      (st_q.tail),
    .pend      (spec_pend)
);

// File: tb/test_nl_xlate_tx.sv
`timescale 1ns/1ps
module test_nl_xlate_tx;
    localparam logic [7:0] CR = 8'h0D;
    localparam logic [7:0] NL = 8'h0A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] out_data;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic       inj_req = 1'b0;
    logic [7:0] inj_char = '0;
    logic       inj_done;

    int checks = 0;
    int errors = 0;

    logic [7:0] stim[$];
    logic [7:0] expq[$];
    logic [7:0] got[$];
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    nl_xlate_tx i_nl_xlate_tx (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .inj_req(inj_req), .inj_char(inj_char), .inj_done(inj_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic void build(input logic [1:0] m, input int ipos, input logic [7:0] ichr);
        expq.delete();
        foreach (stim[i]) begin
            if (stim[i] == CR && m[0]) expq.push_back(NL);
            else if (stim[i] == NL && m[1]) begin
                expq.push_back(CR);
                expq.push_back(NL);
            end else expq.push_back(stim[i]);
        end
        if (ipos >= 0) expq.insert(ipos, ichr);
    endfunction

    task automatic run(input logic [1:0] m, input bit rnd, input int hold,
                       input int i1_at, input logic [7:0] i1_chr,
                       input int i2_at, input logic [7:0] i2_chr,
                       input int ipos, input string req);
        int idx = 0, cyc = 0, pops = 0, ndone = 0, done_cyc = -1, fire_cyc = -1, bad = -1;
        build(m, ipos, i1_chr);
        got.delete();
        mode = m;
        while (got.size() < expq.size() && cyc < 5000) begin
            @(negedge clk);
            lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready = (cyc >= hold) && (!rnd || lfsr[0]);
            in_valid  = idx < stim.size();
            in_data   = in_valid ? stim[idx] : 8'h00;
            inj_req   = (cyc == i1_at) || (cyc == i2_at);
            inj_char  = (cyc == i2_at) ? i2_chr : i1_chr;
            #1;
            if (inj_done) begin ndone++; done_cyc = cyc; end
            if (out_valid && out_ready) begin
                if (got.size() == ipos) fire_cyc = cyc;
                got.push_back(out_data);
            end
            if (in_valid && in_ready) begin idx++; pops++; end
            cyc++;
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            out_ready = 1'b0; in_valid = 1'b0; inj_req = 1'b0;
            #1;
            if (inj_done) begin ndone++; done_cyc = cyc; end
            cyc++;
        end
        chk(cyc < 5000 + 3, {req, " watchdog"}, cyc, 5000);
        chk(got.size() == expq.size(), {req, " length"}, got.size(), expq.size());
        foreach (expq[i]) if (bad < 0 && (i >= got.size() || got[i] != expq[i])) bad = i;
        if (bad >= 0)
            chk(1'b0, {req, " stream"}, (bad < got.size()) ? got[bad] : -1, expq[bad]);
        else
            chk(1'b1, req, 0, 0);
        chk(pops == stim.size(), {req, " R6 pops"}, pops, stim.size());
        if (ipos >= 0) begin
            chk(ndone == 1, {req, " R8 done count"}, ndone, 1);
            chk(done_cyc == fire_cyc + 1, {req, " R8 done cycle"}, done_cyc, fire_cyc + 1);
        end else begin
            chk(ndone == 0, {req, " R8 no done"}, ndone, 0);
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        string tags[4];
        tags[0] = "R1"; tags[1] = "R2"; tags[2] = "R3"; tags[3] = "R4";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R12 out_valid", out_valid, 0);
        chk(inj_done == 1'b0, "R12 inj_done", inj_done, 0);

        // full byte sweep in every mode, steady and random backpressure (R10)
        for (int m = 0; m < 4; m++) begin
            for (int r = 0; r < 2; r++) begin
                stim.delete();
                for (int b = 0; b < 256; b++) stim.push_back(8'(b));
                stim.push_back(CR); stim.push_back(NL); stim.push_back(NL);
                stim.push_back(CR); stim.push_back(CR); stim.push_back(8'h41);
                stim.push_back(NL);
                run(2'(m), r[0], 0, -1, 8'h00, -1, 8'h00, -1,
                    r ? {tags[m], " R10 random ready"} : tags[m]);
            end
        end

        // R5 R9: stalled queue, special CR inserted first and untranslated
        stim.delete(); stim.push_back(8'h41); stim.push_back(8'h42);
        run(2'b11, 1'b0, 3, 0, CR, -1, 8'h00, 0, "R5 R9 preempt");

        // R7: request during expansion waits for the NL half
        stim.delete(); stim.push_back(NL); stim.push_back(8'h43);
        run(2'b10, 1'b0, 0, 0, 8'h55, -1, 8'h00, 2, "R7 after split");

        // R11: second request while pending is dropped
        stim.delete(); stim.push_back(8'h61); stim.push_back(8'h62);
        run(2'b00, 1'b0, 4, 0, 8'h11, 2, 8'h22, 0, "R11 ignore second");

        // R9: special NL with empty queue in mode 01, sent as NL only
        stim.delete();
        run(2'b01, 1'b0, 0, 0, NL, -1, 8'h00, 0, "R9 empty queue");

        // R4: run of CRs in mode 11 gives exactly one NL each, random ready
        stim.delete();
        for (int k = 0; k < 20; k++) stim.push_back((k % 3 == 0) ? NL : CR);
        run(2'b11, 1'b1, 0, -1, 8'h00, -1, 8'h00, -1, "R4 R10 cr runs");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule